// File: doc/BRIEF.md
# Display Engine Clock and Reset Control Unit

This block sits beside three display-engine sub-blocks: two mixers (index 0 and 1) and one write-back unit (index 2). It owns their clock gating, bus-clock gating and bus resets. Software programs it through a small 32-bit register bus that has byte-lane strobes.

From the single source clock, the block makes one clock-enable pulse stream per sub-block. Each stream has its own 4-bit divide field, and the ratio is the field value plus one. Downstream logic qualifies its flops with these pulses instead of using derived clocks.

Each sub-block also gets a bus-clock enable and an active-low bus reset. Both follow their register bits directly. A build-time parameter selects a variant in which one reset bit drives both the write-back unit and the second mixer.

Top module: `dce_ctrl`

## Requirements
- R1: After a synchronous reset, all five registers read 0. `mod_en`, `bus_en` and `bus_rst_n` are then all 0, so every sub-block is gated off and held in reset.
- R2: The registers sit at byte offsets 0x00, 0x04, 0x08, 0x0C and 0x10:
  - 0x00 is the module gate.
  - 0x04 is the bus gate.
  - 0x08 is the reset bits.
  - 0x0C is the divide fields.
  - 0x10 is the select storage.
  
  In the gate and reset registers, bit 0 is mixer 0, bit 1 is mixer 1 and bit 2 is write-back, and bits 31:3 read 0. In the divide register, mixer 0 is bits 3:0, mixer 1 is bits 7:4 and write-back is bits 11:8, and bits 31:12 read 0.
- R3: A write changes only the bytes whose `bus_be` bit is 1. Strobe bit k covers data bits 8k+7:8k.
- R4: `bus_en[i]` equals bit i of the bus-gate register from the cycle after the write edge.
- R5: With module-gate bit i set and divide field N, `mod_en[i]` is a one-cycle pulse every N+1 cycles. The first pulse comes N cycles after the first gated-on cycle. With N = 0 the pulse is present every cycle.
- R6: While module-gate bit i is 0, `mod_en[i]` is 0 and that divider counter stays at zero. Re-enabling restarts the count, so the first pulse again comes N cycles later.
- R7: A new divide value takes effect only at a counter wrap. The pulse spacing therefore moves from the old period to the new one with no other spacing in between.
- R8: With the variant parameter at 0, `bus_rst_n[i]` is 0 while reset bit i is 0. It goes to 1 in the cycle after a write sets that bit.
- R9: With the variant parameter at 1, reset bit 2 drives both `bus_rst_n[2]` and `bus_rst_n[1]`, and reset bit 1 has no effect on any output.
- R10: The register at 0x10 stores all 32 bits and affects no output.
- R11: An access is ignored in two cases: an offset above 0x10, or a nonzero `bus_addr[1:0]`. Such a read returns 0 and such a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mod_en | output | 3 | Per-sub-block divided, gated clock-enable pulse |
| bus_en | output | 3 | Per-sub-block bus-clock enable |
| bus_rst_n | output | 3 | Per-sub-block active-low bus reset |

## Verification
A write to the divide register can land on the same edge as a counter wrap. At that edge the divider reloads its ratio from the register while the register itself is changing. The bench runs one divider at a ratio of four and sweeps the write over every phase of the count, so one of the phases hits the wrap edge exactly. It then records the spacing between all pulses before and after the write. The record must contain only the old spacing followed by the new one: no short, merged or lost period, and never the old spacing again once the new one has appeared.

// File: rtl/dce_pkg.sv
package dce_pkg;

    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int NUM_SUB = 3;
    localparam int DIV_W   = 4;
    localparam int NUM_REGS = 5;

    // sub-block indices
    localparam int SUB_MIX0 = 0;
    localparam int SUB_MIX1 = 1;
    localparam int SUB_WB   = 2;

    typedef enum int {
        REG_MOD_GATE = 0,
        REG_BUS_GATE = 1,
        REG_BUS_RST  = 2,
        REG_DIV      = 3,
        REG_SEL      = 4
    } reg_idx_e;

    typedef struct packed {
        logic [NUM_SUB-1:0]       mod_gate;
        logic [NUM_SUB-1:0]       bus_gate;
        logic [NUM_SUB-1:0]       rst_bit;
        logic [NUM_SUB*DIV_W-1:0] div;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] nxt,
        input logic [BE_W-1:0]   be
    );
        logic [DATA_W-1:0] r;
        r = cur;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[b*8 +: 8] = nxt[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        if (idx == int'(REG_MOD_GATE) || idx == int'(REG_BUS_GATE) ||
            idx == int'(REG_BUS_RST))
            m[NUM_SUB-1:0] = '1;
        else if (idx == int'(REG_DIV))
            m[NUM_SUB*DIV_W-1:0] = '1;
        else if (idx == int'(REG_SEL))
            m = '1;
        return m;
    endfunction

endpackage

// File: rtl/dce_regs.sv
module dce_regs
    import dce_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BE_W-1:0]     be,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output ctrl_t               ctrl
);
    localparam int IDX_W = ADDR_W - 2;

    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [IDX_W-1:0]  idx;
    logic              aligned;
    logic              hit;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign hit     = aligned && (int'(idx) < NUM_REGS);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (wr && hit && (idx == IDX_W'(g))) begin
                regs_q[g] <= merge_bytes(regs_q[g], wdata, be) & reg_mask(g);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit && (idx == IDX_W'(k))) rdata = regs_q[k];
        end
    end

    assign ctrl.mod_gate = regs_q[int'(REG_MOD_GATE)][NUM_SUB-1:0];
    assign ctrl.bus_gate = regs_q[int'(REG_BUS_GATE)][NUM_SUB-1:0];
    assign ctrl.rst_bit  = regs_q[int'(REG_BUS_RST)][NUM_SUB-1:0];
    assign ctrl.div      = regs_q[int'(REG_DIV)][NUM_SUB*DIV_W-1:0];

endmodule

// File: rtl/dce_clkdiv.sv
module dce_clkdiv
    import dce_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate,
    input  logic [W-1:0] ratio,
    output logic         en_pulse
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;
    logic         wrap;

    assign wrap = (cnt_q == lim_q);

    // The limit is reloaded only while stopped or at a wrap.
    always_ff @(posedge clk) begin
        if (rst || !gate) begin
            cnt_q <= '0;
            lim_q <= ratio;
        end else if (wrap) begin
            cnt_q <= '0;
            lim_q <= ratio;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign en_pulse = gate && wrap;

endmodule

// File: rtl/dce_rst_map.sv
module dce_rst_map
    import dce_pkg::*;
#(
    parameter bit SHARED_WB_RST = 1'b0
) (
    input  logic [NUM_SUB-1:0] rst_bit,
    output logic [NUM_SUB-1:0] rst_n
);
    if (SHARED_WB_RST) begin : g_shared
        always_comb begin
            rst_n           = '0;
            rst_n[SUB_MIX0] = rst_bit[SUB_MIX0];
            rst_n[SUB_MIX1] = rst_bit[SUB_WB];
            rst_n[SUB_WB]   = rst_bit[SUB_WB];
        end
    end else begin : g_split
        assign rst_n = rst_bit;
    end

endmodule

// File: rtl/dce_ctrl.sv
module dce_ctrl
    import dce_pkg::*;
#(
    parameter bit SHARED_WB_RST = 1'b0,
    parameter int ADDR_W        = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [3:0]          bus_be,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [2:0]          mod_en,
    output logic [2:0]          bus_en,
    output logic [2:0]          bus_rst_n
);
    ctrl_t ctrl;

    dce_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .be    (bus_be),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .ctrl  (ctrl)
    );

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_div
        dce_clkdiv #(.W(DIV_W)) u_div (
            .clk      (clk),
            .rst      (rst),
            .gate     (ctrl.mod_gate[s]),
            .ratio    (ctrl.div[s*DIV_W +: DIV_W]),
            .en_pulse (mod_en[s])
        );
    end

    dce_rst_map #(.SHARED_WB_RST(SHARED_WB_RST)) u_rst (
        .rst_bit (ctrl.rst_bit),
        .rst_n   (bus_rst_n)
    );

    assign bus_en = ctrl.bus_gate;

endmodule

// File: rtl/dce_ctrl_chk.sv
module dce_ctrl_chk #(
    parameter bit SHARED_WB_RST = 1'b0,
    parameter int ADDR_W        = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [2:0]        wdata_lo,
    input logic [2:0]        mod_en,
    input logic [2:0]        bus_en,
    input logic [2:0]        bus_rst_n
);
    logic wr_bgate, wr_rst, wr_unmapped;

    assign wr_bgate    = bus_wr && (bus_addr == ADDR_W'(8'h04));
    assign wr_rst      = bus_wr && (bus_addr == ADDR_W'(8'h08));
    assign wr_unmapped = bus_wr && ((bus_addr[1:0] != 2'b00) ||
                                    (bus_addr > ADDR_W'(8'h10)));

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mod_en == 3'b000 && bus_en == 3'b000 && bus_rst_n == 3'b000)); // R1

    AST_BUS_EN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (wr_bgate && bus_be[0]) |=> (bus_en == $past(wdata_lo))); // R4

    AST_RST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (wr_rst && bus_be[0] && wdata_lo[0]) |=> bus_rst_n[0]); // R8

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        wr_unmapped |=> ($stable(bus_en) && $stable(bus_rst_n))); // R11

    if (SHARED_WB_RST) begin : g_sh
        AST_SHARED_BIT1_DEAD: assert property (@(posedge clk) disable iff (rst)
            (wr_rst && bus_be[0] && wdata_lo[1] && !wdata_lo[2]) |=> !bus_rst_n[1]); // R9
    end else begin : g_sp
        AST_SPLIT_BIT1: assert property (@(posedge clk) disable iff (rst)
            (wr_rst && bus_be[0]) |=> (bus_rst_n[1] == $past(wdata_lo[1]))); // R8
    end

endmodule

bind dce_ctrl dce_ctrl_chk #(.SHARED_WB_RST(SHARED_WB_RST), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .wdata_lo  (bus_wdata[2:0]),
    .mod_en    (mod_en),
    .bus_en    (bus_en),
    .bus_rst_n (bus_rst_n)
);

// File: tb/tb_dce_ctrl.sv
module tb_dce_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_sh;
    logic [2:0]  mod_en, bus_en, bus_rst_n;
    logic [2:0]  mod_en_sh, bus_en_sh, bus_rst_n_sh;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dce_ctrl #(.SHARED_WB_RST(1'b0), .ADDR_W(5)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .mod_en(mod_en), .bus_en(bus_en), .bus_rst_n(bus_rst_n)
    );

    dce_ctrl #(.SHARED_WB_RST(1'b1), .ADDR_W(5)) dut_sh (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_sh),
        .mod_en(mod_en_sh), .bus_en(bus_en_sh), .bus_rst_n(bus_rst_n_sh)
    );

    // pulse-time recorder for mixer 0
    int cyc = 0;
    bit rec = 1'b0;
    int ptimes [64];
    int pcount = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rec && mod_en[0] && pcount < 64) begin
            ptimes[pcount] = cyc;
            pcount = pcount + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "mod_en", {29'd0, mod_en}, 32'd0);
        chk("R1", "bus_en", {29'd0, bus_en}, 32'd0);
        chk("R1", "bus_rst_n", {29'd0, bus_rst_n}, 32'd0);
        for (int r = 0; r < 5; r++) begin
            rd(5'(r * 4), v);
            chk("R1", "reg readback", v, 32'd0);
        end

        // R2 reserved bits read zero, R4 bus gate
        wr(5'h00, 32'hFFFF_FFFF, 4'hF); rd(5'h00, v); chk("R2", "mod gate mask", v, 32'h7);
        wr(5'h04, 32'hFFFF_FFFF, 4'hF); rd(5'h04, v); chk("R2", "bus gate mask", v, 32'h7);
        chk("R4", "bus_en all", {29'd0, bus_en}, 32'h7);
        wr(5'h04, 32'h5, 4'h1);
        #1 chk("R4", "bus_en 101", {29'd0, bus_en}, 32'h5);
        wr(5'h08, 32'hFFFF_FFF8, 4'hF); rd(5'h08, v); chk("R2", "rst mask", v, 32'h0);
        wr(5'h0C, 32'hFFFF_FFFF, 4'hF); rd(5'h0C, v); chk("R2", "div mask", v, 32'hFFF);
        wr(5'h00, 32'h0, 4'hF); wr(5'h04, 32'h0, 4'hF); wr(5'h0C, 32'h0, 4'hF);
        #1 chk("R4", "bus_en cleared", {29'd0, bus_en}, 32'h0);

        // R3 byte strobes, R10 select storage
        wr(5'h10, 32'hAABB_CCDD, 4'hF);
        wr(5'h10, 32'h1122_3344, 4'h5);
        rd(5'h10, v); chk("R3", "sel strobes", v, 32'hAA22_CC44);
        chk("R10", "sel no bus_en effect", {29'd0, bus_en}, 32'h0);
        chk("R10", "sel no rst effect", {29'd0, bus_rst_n}, 32'h0);
        chk("R10", "sel no mod_en effect", {29'd0, mod_en}, 32'h0);
        wr(5'h0C, 32'h0000_0FFF, 4'h2); rd(5'h0C, v); chk("R3", "div byte1 only", v, 32'hF00);
        wr(5'h0C, 32'h0, 4'hF);

        // R11 unmapped and misaligned
        wr(5'h14, 32'hFFFF_FFFF, 4'hF); rd(5'h14, v); chk("R11", "read 0x14", v, 32'h0);
        wr(5'h01, 32'hFFFF_FFFF, 4'hF); rd(5'h00, v); chk("R11", "misaligned write", v, 32'h0);
        wr(5'h05, 32'hFFFF_FFFF, 4'hF); rd(5'h04, v); chk("R11", "misaligned bgate", v, 32'h0);
        wr(5'h10, 32'h1234_5678, 4'hF);
        rd(5'h11, v); chk("R11", "misaligned read", v, 32'h0);
        chk("R11", "bus_en untouched", {29'd0, bus_en}, 32'h0);
        wr(5'h1C, 32'hFFFF_FFFF, 4'hF); rd(5'h10, v); chk("R11", "sel unchanged", v, 32'h1234_5678);

        // R8 / R9 reset mapping
        wr(5'h08, 32'h1, 4'h1);
        #1 chk("R8", "rst mix0", {29'd0, bus_rst_n}, 32'h1);
        chk("R9", "shared rst mix0", {29'd0, bus_rst_n_sh}, 32'h1);
        wr(5'h08, 32'h2, 4'h1);
        #1 chk("R8", "rst mix1", {29'd0, bus_rst_n}, 32'h2);
        chk("R9", "shared bit1 dead", {29'd0, bus_rst_n_sh}, 32'h0);
        wr(5'h08, 32'h4, 4'h1);
        #1 chk("R8", "rst wb", {29'd0, bus_rst_n}, 32'h4);
        chk("R9", "shared wb+mix1", {29'd0, bus_rst_n_sh}, 32'h6);
        wr(5'h08, 32'h0, 4'h1);
        #1 chk("R8", "rst all held", {29'd0, bus_rst_n}, 32'h0);

        // R5 divider sweep over every sub-block and every ratio
        for (int s = 0; s < 3; s++) begin
            for (int n = 0; n < 16; n++) begin
                int cnt;
                int first;
                bit other;
                cnt = 0; first = -1; other = 1'b0;
                wr(5'h0C, 32'(n) << (4 * s), 4'h3);
                wr(5'h00, 32'(1) << s, 4'h1);
                for (int k = 0; k < 48; k++) begin
                    #1;
                    if (mod_en[s]) begin
                        cnt++;
                        if (first < 0) first = k;
                    end
                    if ((mod_en & ~(3'(1) << s)) != 3'b000) other = 1'b1;
                    @(negedge clk);
                end
                wr(5'h00, 32'h0, 4'h1);
                chk("R5", $sformatf("pulse count s%0d n%0d", s, n), 32'(cnt), 32'(48 / (n + 1)));
                chk("R5", $sformatf("first pulse s%0d n%0d", s, n), 32'(first), 32'(n));
                chk("R6", $sformatf("other gated s%0d n%0d", s, n), 32'(other), 32'd0);
            end
        end

        // R6 gate off holds, restart from zero
        begin
            int bad;
            int first;
            bad = 0; first = -1;
            wr(5'h0C, 32'h20, 4'h1);
            wr(5'h00, 32'h2, 4'h1);
            repeat (4) @(negedge clk);
            wr(5'h00, 32'h0, 4'h1);
            for (int k = 0; k < 10; k++) begin
                #1 if (mod_en != 3'b000) bad++;
                @(negedge clk);
            end
            chk("R6", "gated quiet", 32'(bad), 32'd0);
            wr(5'h00, 32'h2, 4'h1);
            for (int k = 0; k < 8; k++) begin
                #1 if (mod_en[1] && first < 0) first = k;
                @(negedge clk);
            end
            chk("R6", "restart first pulse", 32'(first), 32'd2);
            wr(5'h00, 32'h0, 4'h1);
        end

        // R7 ratio change at every phase of the count
        for (int p = 0; p < 4; p++) begin
            int bad;
            int last;
            bit seen_new;
            bad = 0; last = 0; seen_new = 1'b0;
            wr(5'h0C, 32'h3, 4'h1);
            pcount = 0;
            rec = 1'b1;
            wr(5'h00, 32'h1, 4'h1);
            repeat (p + 5) @(negedge clk);
            wr(5'h0C, 32'h1, 4'h1);
            repeat (30) @(negedge clk);
            rec = 1'b0;
            wr(5'h00, 32'h0, 4'h1);
            for (int i = 1; i < pcount; i++) begin
                last = ptimes[i] - ptimes[i-1];
                if (last == 2) seen_new = 1'b1;
                else if (last != 4 || seen_new) bad++;
            end
            chk("R7", $sformatf("spacing phase %0d", p), 32'(bad), 32'd0);
            chk("R7", $sformatf("final spacing phase %0d", p), 32'(last), 32'd2);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule